// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept or thrown away, using the 48-bit destination address at the head of the frame and a small set of control settings. The address bytes arrive one per cycle after a start-of-frame strobe. Each byte is shifted into a capture register and folded into a running CRC-32 that yields a 6-bit hash index. When the receive path signals the end of the frame, it also reports whether the frame qualified as a valid PAUSE frame. One cycle later the filter presents a registered verdict: accept, a miss flag, and a flush request.

The checks run in layers. A broadcast address is handled first, then a group address, then an individual address. For the last two, an exact comparison is tried before the hash tables. When nothing matches, the promiscuous setting decides, and the miss flag records that the frame was kept without a real match. When flow control is on, a valid PAUSE frame sent to the reserved PAUSE address or to the station address is always dropped.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `accept`, `miss` and `flush` are all 0.
- R2: `dec_valid` is 1 in exactly the cycle after the cycle where `frame_end` is sampled 1, and 0 otherwise. `accept` and `miss` are 0 whenever `dec_valid` is 0.
- R3: A destination of all ones (broadcast) with `bcast_rej`=0 is accepted with `miss`=0.
- R4: A broadcast destination with `bcast_rej`=1 is accepted with `miss`=1 when `prom_en`=1, and rejected otherwise.
- R5: An individual address has bit 0 of the first received byte equal to 0. If it equals `station_addr` (first byte in bits 47:40), the frame is accepted with `miss`=0, unless R8 applies.
- R6: The hash index is bits 31:26 of a CRC-32 computed over the six address bytes. The CRC uses polynomial 0x04C11DB7, starts from all ones, takes each byte least significant bit first, and is not inverted. The index selects a bit of `ind_hash` or `grp_hash`. An individual address that fails R5 and whose `ind_hash` bit is 1 is accepted with `miss`=0.
- R7: A group address (bit 0 of the first byte is 1, not broadcast) whose `grp_hash` bit is 1 is accepted with `miss`=0. When `flow_en`=1, the address 01:80:C2:00:00:01 is accepted by exact match, unless R8 applies.
- R8: With `flow_en`=1 and `pause_ok`=1 at `frame_end`, a frame addressed to 01:80:C2:00:00:01 or to `station_addr` is rejected, whatever `prom_en` is.
- R9: A non-broadcast frame with no exact or hash match is accepted with `miss`=1 when `prom_en`=1, and rejected otherwise.
- R10: `flush` is 1 exactly when `dec_valid` is 1 and `accept` is 0.
- R11: Only the first six bytes after `sof` form the address. Later bytes with `byte_valid` high do not affect the verdict.
- R12: With `flow_en`=0, `pause_ok` has no effect on the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame strobe; clears address and CRC state |
| byte_valid | input | 1 | A received byte is present on `byte_data` |
| byte_data | input | 8 | Received byte |
| frame_end | input | 1 | End-of-frame strobe; requests a verdict |
| pause_ok | input | 1 | Frame qualified as a valid PAUSE frame (sampled with `frame_end`) |
| station_addr | input | 48 | Station individual address, first byte in bits 47:40 |
| ind_hash | input | 64 | Individual-address hash table |
| grp_hash | input | 64 | Group-address hash table |
| flow_en | input | 1 | Flow control enable |
| prom_en | input | 1 | Promiscuous enable |
| bcast_rej | input | 1 | Broadcast reject |
| dec_valid | output | 1 | Verdict valid pulse |
| accept | output | 1 | Frame accepted |
| miss | output | 1 | Accepted without an address match |
| flush | output | 1 | Discard the rejected frame |

## Verification
The assertions check the output handshake on every cycle. They confirm that each end-of-frame strobe yields one verdict pulse, that flush is always the complement of accept during that pulse, and that a miss only appears on an accepted verdict. They cannot tell whether a given address should pass. That is covered by the bench sweep, which runs every control combination, PAUSE qualification and hash-table setting over broadcast, group, PAUSE, station, near-station and foreign addresses. It also shows the CRC hash selection and the fact that bytes after the sixth are ignored.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int BYTE_W    = 8;
  localparam int DA_BYTES  = 6;
  localparam int MAC_W     = BYTE_W * DA_BYTES;
  localparam int CRC_W     = 32;
  localparam int HASH_BITS = 6;
  localparam int HASH_SIZE = 1 << HASH_BITS;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [MAC_W-1:0] PAUSE_DA = 48'h0180C2000001;

  typedef struct packed {
    logic accept;
    logic miss;
  } verdict_t;
endpackage

// File: rtl/rxf_da_capture.sv
module rxf_da_capture #(
  parameter int BYTE_W   = 8,
  parameter int DA_BYTES = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         sof,
  input  logic                         byte_valid,
  input  logic [BYTE_W-1:0]            byte_data,
  output logic                         take,
  output logic [BYTE_W*DA_BYTES-1:0]   da
);
  localparam int CNT_W = $clog2(DA_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DA_BYTES);

  logic [CNT_W-1:0] cnt;

  assign take = byte_valid && !sof && (cnt < LAST);

  always_ff @(posedge clk) begin
    if (rst || sof) begin
      cnt <= '0;
      da  <= '0;
    end else if (take) begin
      cnt <= cnt + 1'b1;
      da  <= {da[BYTE_W*(DA_BYTES-1)-1:0], byte_data};
    end
  end
endmodule

// File: rtl/rxf_crc_hash.sv
module rxf_crc_hash #(
  parameter int              BYTE_W    = 8,
  parameter int              CRC_W     = 32,
  parameter logic [CRC_W-1:0] POLY     = 32'h04C11DB7,
  parameter int              HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sof,
  input  logic                 take,
  input  logic [BYTE_W-1:0]    byte_data,
  output logic [HASH_BITS-1:0] idx
);
  logic [CRC_W-1:0] crc, crc_nxt;

  always_comb begin
    logic fb;
    crc_nxt = crc;
    for (int i = 0; i < BYTE_W; i++) begin
      fb      = crc_nxt[CRC_W-1] ^ byte_data[i];
      crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || sof)
      crc <= '1;
    else if (take)
      crc <= crc_nxt;
  end

  assign idx = crc[CRC_W-1 -: HASH_BITS];
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int DA_BYTES  = 6,
  parameter int HASH_BITS = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [BYTE_W*DA_BYTES-1:0]    da,
  input  logic [HASH_BITS-1:0]          idx,
  input  logic [BYTE_W*DA_BYTES-1:0]    station_addr,
  input  logic [(1<<HASH_BITS)-1:0]     ind_hash,
  input  logic [(1<<HASH_BITS)-1:0]     grp_hash,
  input  logic                          flow_en,
  input  logic                          prom_en,
  input  logic                          bcast_rej,
  input  logic                          frame_end,
  input  logic                          pause_ok,
  output logic                          dec_valid,
  output logic                          accept,
  output logic                          miss,
  output logic                          flush
);
  localparam int W       = BYTE_W * DA_BYTES;
  localparam int GRP_BIT = BYTE_W * (DA_BYTES - 1);

  logic     is_bc, is_grp, stn_hit, pse_hit, pause_rej, ihit, ghit;
  verdict_t fallback, v;

  assign is_bc     = &da;
  assign is_grp    = da[GRP_BIT];
  assign stn_hit   = (da == station_addr);
  assign pse_hit   = (da == W'(PAUSE_DA));
  assign pause_rej = flow_en && pause_ok && (pse_hit || stn_hit);
  assign ihit      = ind_hash[idx];
  assign ghit      = grp_hash[idx];
  assign fallback  = prom_en ? '{accept: 1'b1, miss: 1'b1} : '{accept: 1'b0, miss: 1'b0};

  always_comb begin
    v = '{accept: 1'b0, miss: 1'b0};
    if (pause_rej)
      v = '{accept: 1'b0, miss: 1'b0};
    else if (is_bc)
      v = !bcast_rej ? '{accept: 1'b1, miss: 1'b0} : fallback;
    else if (is_grp)
      v = ((flow_en && pse_hit) || ghit) ? '{accept: 1'b1, miss: 1'b0} : fallback;
    else
      v = (stn_hit || ihit) ? '{accept: 1'b1, miss: 1'b0} : fallback;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid <= 1'b0;
      accept    <= 1'b0;
      miss      <= 1'b0;
      flush     <= 1'b0;
    end else begin
      dec_valid <= frame_end;
      accept    <= frame_end && v.accept;
      miss      <= frame_end && v.miss;
      flush     <= frame_end && !v.accept;
    end
  end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import rxf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sof,
  input  logic                 byte_valid,
  input  logic [BYTE_W-1:0]    byte_data,
  input  logic                 frame_end,
  input  logic                 pause_ok,
  input  logic [MAC_W-1:0]     station_addr,
  input  logic [HASH_SIZE-1:0] ind_hash,
  input  logic [HASH_SIZE-1:0] grp_hash,
  input  logic                 flow_en,
  input  logic                 prom_en,
  input  logic                 bcast_rej,
  output logic                 dec_valid,
  output logic                 accept,
  output logic                 miss,
  output logic                 flush
);
  logic                 take;
  logic [MAC_W-1:0]     da;
  logic [HASH_BITS-1:0] idx;

  rxf_da_capture #(.BYTE_W(BYTE_W), .DA_BYTES(DA_BYTES)) u_cap (
    .clk(clk), .rst(rst), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .take(take), .da(da)
  );

  rxf_crc_hash #(.BYTE_W(BYTE_W), .CRC_W(CRC_W), .POLY(CRC_POLY),
                 .HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst(rst), .sof(sof), .take(take),
    .byte_data(byte_data), .idx(idx)
  );

  rxf_decide #(.BYTE_W(BYTE_W), .DA_BYTES(DA_BYTES), .HASH_BITS(HASH_BITS)) u_dec (
    .clk(clk), .rst(rst), .da(da), .idx(idx), .station_addr(station_addr),
    .ind_hash(ind_hash), .grp_hash(grp_hash), .flow_en(flow_en),
    .prom_en(prom_en), .bcast_rej(bcast_rej), .frame_end(frame_end),
    .pause_ok(pause_ok), .dec_valid(dec_valid), .accept(accept),
    .miss(miss), .flush(flush)
  );
endmodule

// File: rtl/eth_rx_addr_filter_chk.sv
module eth_rx_addr_filter_chk (
  input logic clk,
  input logic rst,
  input logic frame_end,
  input logic dec_valid,
  input logic accept,
  input logic miss,
  input logic flush
);
  a_r2_valid_follows_end: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> dec_valid);

  a_r2_valid_needs_end: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(frame_end));

  a_r2_quiet_between: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!accept && !miss));

  a_r10_flush_is_reject: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (flush == !accept));

  a_r10_flush_in_window: assert property (@(posedge clk) disable iff (rst)
    flush |-> dec_valid);

  a_r9_miss_on_accept: assert property (@(posedge clk) disable iff (rst)
    miss |-> accept);
endmodule

bind eth_rx_addr_filter eth_rx_addr_filter_chk u_chk (
  .clk(clk), .rst(rst), .frame_end(frame_end), .dec_valid(dec_valid),
  .accept(accept), .miss(miss), .flush(flush)
);

// File: tb/eth_rx_addr_filter_test.sv
module eth_rx_addr_filter_test;
  localparam int PERIOD = 10;
  localparam logic [47:0] STN   = 48'h021122334455;
  localparam logic [47:0] PAUSE = 48'h0180C2000001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sof = 1'b0, byte_valid = 1'b0, frame_end = 1'b0, pause_ok = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [47:0] station_addr = STN;
  logic [63:0] ind_hash = '0, grp_hash = '0;
  logic flow_en = 1'b0, prom_en = 1'b0, bcast_rej = 1'b0;
  logic dec_valid, accept, miss, flush;

  int vectors = 0;
  int miscompares = 0;

  always #(PERIOD/2) clk = ~clk;

  eth_rx_addr_filter uut (
    .clk(clk), .rst(rst), .sof(sof), .byte_valid(byte_valid),
    .byte_data(byte_data), .frame_end(frame_end), .pause_ok(pause_ok),
    .station_addr(station_addr), .ind_hash(ind_hash), .grp_hash(grp_hash),
    .flow_en(flow_en), .prom_en(prom_en), .bcast_rej(bcast_rej),
    .dec_valid(dec_valid), .accept(accept), .miss(miss), .flush(flush)
  );

  function automatic logic [5:0] hash_of(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int b = 5; b >= 0; b--) begin
      for (int i = 0; i < 8; i++) begin
        logic fb = c[31] ^ a[b*8+i];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    return c[31:26];
  endfunction

  // returns {accept, miss}
  function automatic logic [1:0] model(input logic [47:0] a, input logic fl,
      input logic pr, input logic br, input logic pz,
      input logic [63:0] ih, input logic [63:0] gh);
    logic [5:0] h = hash_of(a);
    logic [1:0] none = pr ? 2'b11 : 2'b00;
    if (fl && pz && (a == PAUSE || a == STN)) return 2'b00;        // R8
    if (a == '1) return br ? none : 2'b10;                          // R3 R4
    if (a[40]) return ((fl && a == PAUSE) || gh[h]) ? 2'b10 : none; // R7 R9
    return (a == STN || ih[h]) ? 2'b10 : none;                      // R5 R6 R9
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got {valid,acc,miss,flush}=%b expected %b", tag, got, exp);
    end
  endtask

  task automatic run_frame(input logic [47:0] a, input int extra,
                           input logic [7:0] extra_val, input logic pz);
    @(negedge clk) sof = 1'b1;
    @(negedge clk) sof = 1'b0;
    for (int b = 5; b >= 0; b--) begin
      byte_valid = 1'b1; byte_data = a[b*8 +: 8];
      @(negedge clk);
    end
    for (int e = 0; e < extra; e++) begin
      byte_data = extra_val;
      @(negedge clk);
    end
    byte_valid = 1'b0;
    frame_end = 1'b1; pause_ok = pz;
    @(negedge clk) frame_end = 1'b0; pause_ok = 1'b0;
  endtask

  task automatic frame_and_check(input string tag, input logic [47:0] a,
                                 input int extra, input logic [7:0] xv, input logic pz);
    logic [1:0] e = model(a, flow_en, prom_en, bcast_rej, pz, ind_hash, grp_hash);
    run_frame(a, extra, xv, pz);
    check(tag, {dec_valid, accept, miss, flush}, {1'b1, e, ~e[1]});
    @(negedge clk);
    check("R2 pulse ends", {dec_valid, accept, miss, flush}, 4'b0000);
  endtask

  initial begin
    #(PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [47:0] das [6];
    das[0] = '1; das[1] = PAUSE; das[2] = STN; das[3] = STN ^ 48'h1;
    das[4] = 48'h01005E010203; das[5] = 48'h0ABBCCDDEEF0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {dec_valid, accept, miss, flush}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {dec_valid, accept, miss, flush}, 4'b0000);

    for (int d = 0; d < 6; d++)
      for (int cfg = 0; cfg < 8; cfg++)
        for (int hm = 0; hm < 3; hm++)
          for (int pz = 0; pz < 2; pz++) begin
            flow_en = cfg[0]; prom_en = cfg[1]; bcast_rej = cfg[2];
            ind_hash = (hm == 1) ? (64'h1 << hash_of(das[d])) : 64'h0;
            grp_hash = (hm == 2) ? (64'h1 << hash_of(das[d])) : 64'h0;
            frame_and_check("R3-R10,R12 sweep", das[d], 0, 8'h00, pz[0]);
          end

    // R11: trailing bytes after the sixth do not change the address
    flow_en = 1'b0; prom_en = 1'b0; bcast_rej = 1'b0; ind_hash = '0; grp_hash = '0;
    frame_and_check("R11 extra bytes station", STN, 4, 8'hFF, 1'b0);
    frame_and_check("R11 extra bytes foreign", das[5], 3, 8'h55, 1'b0);
    // R6: full hash table accepts any individual address
    ind_hash = '1;
    frame_and_check("R6 full table", das[5], 0, 8'h00, 1'b0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule